// File: doc/BRIEF.md
# Converter Host Bus Command Sequencer

This block is the clocked, host-facing controller of a self-calibrating analog-to-digital converter. A microprocessor reaches it over an asynchronous bus with active-low chip-select, read and write strobes and a 16-bit data bus. All three strobes pass through a two-flop synchroniser. A write cycle carries a command code in the low six data bits. The block starts either a conversion or a calibration of the converter core, and it counts the clock cycles each operation takes.

When an operation finishes, the block pulls an active-low interrupt. After a conversion it also stores the signed result from the core. A host read then returns that result as a sign-extended two's-complement word. A separate status read returns the calibration-valid flag. A ready output drops for one clock at the start of every host access. This gives a fast host one wait state while the strobes cross into the clock domain.

Top module: `adc_cmd_seq`

## Requirements
- R1: After reset, int_n and ready are 1, bus_oe is 0, no start pulse is issued, the stored result is 0 and the calibration-valid flag is 0.
- R2: A write access is cs_n and wr_n both low. Its command is taken when that combination ends, which is when either strobe returns high. Only bus_in[5:0] selects the command, and bus_in[15:6] has no effect.
- R3: Code 6'b000001 starts a conversion. conv_start pulses high for one clock. int_n falls exactly 24 clocks after that pulse, and in that same cycle core_result is stored.
- R4: Code 6'b000010 starts a calibration. cal_start pulses high for one clock. int_n falls exactly 300 clocks after that pulse, and the calibration-valid flag is set. The flag stays set across later conversions.
- R5: A convert code that arrives while a conversion runs abandons it and restarts the 24-clock count from the new pulse. The abandoned conversion neither stores a result nor lowers int_n.
- R6: While a calibration runs, convert and calibrate codes are ignored. A calibrate code that arrives during a conversion is also ignored.
- R7: int_n returns to 1 at the start of a read access (cs_n and rd_n low) or a write access. If an operation completes in the same cycle, int_n goes to 0.
- R8: During a read access, bus_oe is 1. bus_out carries the 13-bit result in bits 12:0, with bit 12 copied into bits 15:13. Outside a read, bus_oe is 0 and bus_out is 0.
- R9: Code 6'b000100 makes the next read return the flag in bit 15 and zeros in bits 14:0. Reads after that one return the result again.
- R10: ready is 0 for exactly one clock at the start of each read access and each write access, and is 1 otherwise.
- R11: Any other command code changes neither the pulses, the result, the flag nor the read selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host chip-select, active low, asynchronous |
| rd_n | input | 1 | Host read strobe, active low, asynchronous |
| wr_n | input | 1 | Host write strobe, active low, asynchronous |
| bus_in | input | 16 | Host data bus during writes |
| bus_out | output | 16 | Read data: sign-extended result or status word |
| bus_oe | output | 1 | High while bus_out should drive the host bus |
| ready | output | 1 | Low for one clock to stretch a host access |
| int_n | output | 1 | Active-low operation-complete interrupt |
| conv_start | output | 1 | One-clock start pulse to the converter core |
| cal_start | output | 1 | One-clock calibration pulse to the converter core |
| core_result | input | 13 | Signed conversion result from the core |

## Verification
The assertions run on every cycle. They check that the start pulses are single clocks that never overlap, and that ready recovers after one low clock. They check the 24- and 300-clock spacing from each start pulse to the interrupt edge, the sign extension of read data, the zeros in a status word, and a silent bus outside reads. Other behaviour depends on the order of host accesses, so only the bench scenarios can show it. These scenarios cover aborting and restarting a conversion, commands dropped during calibration, interrupt clearing by reads and writes, the one-shot status selection, and the no-op codes. A behavioural model checks all of them cycle by cycle.

// File: rtl/adc_cmd_pkg.sv
package adc_cmd_pkg;
    localparam int CMD_W = 6;

    localparam logic [CMD_W-1:0] CODE_CONV = 6'b000001;
    localparam logic [CMD_W-1:0] CODE_CAL  = 6'b000010;
    localparam logic [CMD_W-1:0] CODE_STAT = 6'b000100;

    typedef enum logic [1:0] {
        OP_IDLE,
        OP_CONV,
        OP_CAL
    } op_e;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_CONV,
        CMD_CAL,
        CMD_STAT
    } cmd_e;
endpackage

// File: rtl/adc_strobe_sync.sv
// Multi-stage synchroniser for active-low asynchronous strobes (idle high).
module adc_strobe_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '1;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/adc_bus_if.sv
// Detects host access combinations, holds the write code and decodes it.
module adc_bus_if
    import adc_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_s,
    input  logic             rd_s,
    input  logic             wr_s,
    input  logic [CMD_W-1:0] code_in,
    output logic             rd_act,
    output logic             rd_begin,
    output logic             rd_end,
    output logic             wr_begin,
    output cmd_e             cmd,
    output logic             ready
);
    typedef struct packed {
        logic             rd_act;
        logic             wr_act;
        logic [CMD_W-1:0] hold;
        logic             ready;
    } bif_t;

    bif_t d, q;
    logic rd_now, wr_now, wr_end;

    always_comb begin
        rd_now   = !cs_s && !rd_s;
        wr_now   = !cs_s && !wr_s;
        rd_begin = rd_now && !q.rd_act;
        rd_end   = !rd_now && q.rd_act;
        wr_begin = wr_now && !q.wr_act;
        wr_end   = !wr_now && q.wr_act;

        d        = q;
        d.rd_act = rd_now;
        d.wr_act = wr_now;
        d.ready  = !(rd_begin || wr_begin);
        if (wr_now) d.hold = code_in;

        cmd = CMD_NONE;
        if (wr_end) begin
            if      (q.hold == CODE_CONV) cmd = CMD_CONV;
            else if (q.hold == CODE_CAL)  cmd = CMD_CAL;
            else if (q.hold == CODE_STAT) cmd = CMD_STAT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{rd_act: 1'b0, wr_act: 1'b0, hold: '0, ready: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign rd_act = q.rd_act;
    assign ready  = q.ready;
endmodule

// File: rtl/adc_cmd_seq.sv
// Top: synchroniser, bus decoder and operation sequencer.
module adc_cmd_seq
    import adc_cmd_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int RES_W       = 13,
    parameter int CONV_CYCLES = 24,
    parameter int CAL_CYCLES  = 300,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic              ready,
    output logic              int_n,
    output logic              conv_start,
    output logic              cal_start,
    input  logic [RES_W-1:0]  core_result
);
    localparam int CNT_W = $clog2(CAL_CYCLES + 1);
    localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYCLES - 1);
    localparam logic [CNT_W-1:0] CAL_LAST  = CNT_W'(CAL_CYCLES - 1);

    typedef struct packed {
        op_e              op;
        logic [CNT_W-1:0] cnt;
        logic             int_n;
        logic [RES_W-1:0] result;
        logic             cal_ok;
        logic             stat_sel;
        logic             conv_go;
        logic             cal_go;
    } seq_t;

    logic [2:0] strobe_s;
    logic       rd_act, rd_begin, rd_end, wr_begin;
    cmd_e       cmd;
    seq_t       d, q;
    logic       done;
    logic       stat_sel_w;
    wire        unused_upper = ^bus_in[DATA_W-1:CMD_W];

    adc_strobe_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({cs_n, rd_n, wr_n}),
        .sync_out (strobe_s)
    );

    adc_bus_if u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_s     (strobe_s[2]),
        .rd_s     (strobe_s[1]),
        .wr_s     (strobe_s[0]),
        .code_in  (bus_in[CMD_W-1:0]),
        .rd_act   (rd_act),
        .rd_begin (rd_begin),
        .rd_end   (rd_end),
        .wr_begin (wr_begin),
        .cmd      (cmd),
        .ready    (ready)
    );

    always_comb begin
        d         = q;
        d.conv_go = 1'b0;
        d.cal_go  = 1'b0;
        done      = ((q.op == OP_CONV) && (q.cnt == CONV_LAST)) ||
                    ((q.op == OP_CAL)  && (q.cnt == CAL_LAST));

        // host access clears the interrupt; completion below takes priority
        if (rd_begin || wr_begin) d.int_n = 1'b1;

        if (q.op != OP_IDLE) begin
            d.cnt = q.cnt + 1'b1;
            if (done) begin
                d.op    = OP_IDLE;
                d.cnt   = '0;
                d.int_n = 1'b0;
                if (q.op == OP_CONV) d.result = core_result;
                else                 d.cal_ok = 1'b1;
            end
        end

        if (rd_end) d.stat_sel = 1'b0;

        case (cmd)
            CMD_CONV: if (d.op != OP_CAL) begin
                d.op      = OP_CONV;
                d.cnt     = '0;
                d.conv_go = 1'b1;
            end
            CMD_CAL: if (d.op == OP_IDLE) begin
                d.op     = OP_CAL;
                d.cnt    = '0;
                d.cal_go = 1'b1;
            end
            CMD_STAT: d.stat_sel = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{op: OP_IDLE, cnt: '0, int_n: 1'b1, result: '0,
                   cal_ok: 1'b0, stat_sel: 1'b0, conv_go: 1'b0, cal_go: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign stat_sel_w = q.stat_sel;
    assign bus_oe     = rd_act;
    assign int_n      = q.int_n;
    assign conv_start = q.conv_go;
    assign cal_start  = q.cal_go;

    always_comb begin
        if (!rd_act)         bus_out = '0;
        else if (stat_sel_w) bus_out = {q.cal_ok, {(DATA_W-1){1'b0}}};
        else                 bus_out = {{(DATA_W-RES_W){q.result[RES_W-1]}}, q.result};
    end
endmodule

// File: rtl/adc_cmd_seq_chk.sv
module adc_cmd_seq_chk #(
    parameter int DATA_W      = 16,
    parameter int RES_W       = 13,
    parameter int CONV_CYCLES = 24,
    parameter int CAL_CYCLES  = 300
) (
    input logic              clk,
    input logic              rst_n,
    input logic              int_n,
    input logic              ready,
    input logic              bus_oe,
    input logic [DATA_W-1:0] bus_out,
    input logic              conv_start,
    input logic              cal_start,
    input logic              stat_sel
);
    localparam int SW = $clog2(CAL_CYCLES + 2) + 1;
    localparam logic [SW-1:0] SAT = {SW{1'b1}};

    logic [SW-1:0] since_q;
    logic          last_conv_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q     <= SAT;
            last_conv_q <= 1'b0;
        end else if (conv_start || cal_start) begin
            since_q     <= SW'(1);
            last_conv_q <= conv_start;
        end else if (since_q != SAT) begin
            since_q <= since_q + 1'b1;
        end
    end

    p_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    p_cal_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |=> !cal_start);
    p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(conv_start && cal_start));
    p_conv_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(int_n) && last_conv_q) |-> (since_q == SW'(CONV_CYCLES)));
    p_cal_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(int_n) && !last_conv_q) |-> (since_q == SW'(CAL_CYCLES)));
    p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> ready);
    p_idle_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_out == '0));
    p_sign_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && !stat_sel) |->
        (($countones(bus_out[DATA_W-1:RES_W-1]) == 0) ||
         ($countones(bus_out[DATA_W-1:RES_W-1]) == DATA_W-RES_W+1)));
    p_stat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && stat_sel) |-> (bus_out[DATA_W-2:0] == '0));
endmodule

bind adc_cmd_seq adc_cmd_seq_chk #(
    .DATA_W(DATA_W), .RES_W(RES_W),
    .CONV_CYCLES(CONV_CYCLES), .CAL_CYCLES(CAL_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .int_n      (int_n),
    .ready      (ready),
    .bus_oe     (bus_oe),
    .bus_out    (bus_out),
    .conv_start (conv_start),
    .cal_start  (cal_start),
    .stat_sel   (stat_sel_w)
);

// File: tb/adc_cmd_seq_bench.sv
module adc_cmd_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CONV_N = 24;
    localparam int CAL_N  = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [15:0] bus_in = '0;
    logic [15:0] bus_out;
    logic        bus_oe, ready, int_n, conv_start, cal_start;
    logic [12:0] core_result = '0;

    int checks = 0;
    int failures = 0;

    adc_cmd_seq u_adc_cmd_seq (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .ready(ready),
        .int_n(int_n), .conv_start(conv_start), .cal_start(cal_start),
        .core_result(core_result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [2:0]  hist[$];
    int          m_op, m_left;
    logic        m_int, m_calok, m_stat, m_cgo, m_kgo, m_oe, m_ready;
    logic [12:0] m_res;
    logic [5:0]  m_hold;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = {3'b111, 3'b111, 3'b111};
            m_op = 0; m_left = 0; m_int = 1; m_calok = 0; m_stat = 0;
            m_cgo = 0; m_kgo = 0; m_oe = 0; m_ready = 1; m_res = '0; m_hold = '0;
        end else begin
            bit rn, rp, wn, wp;
            rn = !hist[1][2] && !hist[1][1];
            rp = !hist[2][2] && !hist[2][1];
            wn = !hist[1][2] && !hist[1][0];
            wp = !hist[2][2] && !hist[2][0];
            m_cgo = 0; m_kgo = 0;
            if ((rn && !rp) || (wn && !wp)) m_int = 1;
            if (m_op != 0) begin
                if (m_left == 1) begin
                    if (m_op == 1) m_res = core_result; else m_calok = 1;
                    m_int = 0; m_op = 0;
                end else m_left--;
            end
            if (!rn && rp) m_stat = 0;
            if (!wn && wp) begin
                if (m_hold == 6'd1 && m_op != 2) begin m_op = 1; m_left = CONV_N; m_cgo = 1; end
                else if (m_hold == 6'd2 && m_op == 0) begin m_op = 2; m_left = CAL_N; m_kgo = 1; end
                else if (m_hold == 6'd4) m_stat = 1;
            end
            if (wn) m_hold = bus_in[5:0];
            m_oe = rn;
            m_ready = !((rn && !rp) || (wn && !wp));
            hist.push_front({cs_n, rd_n, wr_n});
            void'(hist.pop_back());
        end
    end

    // ---------------- per-cycle comparison and monitors ----------------
    int cyc = 0, t_conv = 0, t_cal = 0, t_int = 0;
    int n_conv = 0, n_cal = 0, n_intf = 0, n_rdy = 0;
    logic int_prev = 1'b1;

    always @(negedge clk) begin
        logic [15:0] exp_bus;
        cyc++;
        exp_bus = !m_oe ? 16'h0 : (m_stat ? {m_calok, 15'h0} : {{3{m_res[12]}}, m_res});
        check(conv_start === m_cgo, "R3 conv_start", conv_start, m_cgo);
        check(cal_start === m_kgo, "R4 cal_start", cal_start, m_kgo);
        check(int_n === m_int, "R7 int_n", int_n, m_int);
        check(ready === m_ready, "R10 ready", ready, m_ready);
        check(bus_oe === m_oe, "R8 bus_oe", bus_oe, m_oe);
        check(bus_out === exp_bus, "R8 bus_out", bus_out, exp_bus);
        if (conv_start) begin n_conv++; t_conv = cyc; end
        if (cal_start) begin n_cal++; t_cal = cyc; end
        if (!int_n && int_prev) begin n_intf++; t_int = cyc; end
        if (!ready) n_rdy++;
        int_prev = int_n;
        if (cyc > 150000) begin
            check(1'b0, "watchdog", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // ---------------- host access tasks ----------------
    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input logic [15:0] w);
        @(negedge clk);
        cs_n = 0; wr_n = 0; bus_in = w;
        wait_cyc(4);
        wr_n = 1; cs_n = 1;
        wait_cyc(5);
    endtask

    task automatic host_read(output logic [15:0] v);
        @(negedge clk);
        cs_n = 0; rd_n = 0;
        wait_cyc(4);
        v = bus_out;
        rd_n = 1; cs_n = 1;
        wait_cyc(5);
    endtask

    initial begin
        logic [15:0] rv;
        int nc, nk, nf, r0, t1;
        wait_cyc(3);
        check(int_n === 1 && ready === 1 && bus_oe === 0, "R1 reset outputs",
              {int_n, ready, bus_oe}, 3'b110);
        rst_n = 1;
        wait_cyc(3);
        host_read(rv);
        check(rv === 16'h0000, "R1 result after reset", rv, 0);
        host_write(16'h0004);
        host_read(rv);
        check(rv === 16'h0000, "R9 status flag clear after reset", rv, 0);

        // convert, negative result
        core_result = 13'h1FFB;
        r0 = n_rdy;
        host_write(16'h0001);
        check(n_rdy == r0 + 1, "R10 one ready clock per write", n_rdy - r0, 1);
        wait_cyc(30);
        check(t_int - t_conv == CONV_N, "R3 convert length", t_int - t_conv, CONV_N);
        check(int_n === 0, "R3 interrupt low", int_n, 0);
        r0 = n_rdy;
        host_read(rv);
        check(n_rdy == r0 + 1, "R10 one ready clock per read", n_rdy - r0, 1);
        check(rv === 16'hFFFB, "R8 negative sign extension", rv, 16'hFFFB);
        check(int_n === 1, "R7 read clears interrupt", int_n, 1);

        // upper bits ignored, positive result
        core_result = 13'h0123;
        nc = n_conv;
        host_write(16'hFFC1);
        wait_cyc(30);
        check(n_conv == nc + 1, "R2 upper data bits ignored", n_conv - nc, 1);
        host_read(rv);
        check(rv === 16'h0123, "R8 positive result", rv, 16'h0123);

        // abort and restart
        nf = n_intf;
        core_result = 13'h0555;
        host_write(16'h0001);
        t1 = t_conv;
        wait_cyc(2);
        core_result = 13'h0AAA;
        host_write(16'h0001);
        check(t_conv != t1, "R5 restart pulse issued", t_conv, t1);
        wait_cyc(30);
        check(n_intf == nf + 1, "R5 single interrupt after abort", n_intf - nf, 1);
        check(t_int - t_conv == CONV_N, "R5 count restarts", t_int - t_conv, CONV_N);
        host_read(rv);
        check(rv === 16'h0AAA, "R5 result from restarted conversion", rv, 16'h0AAA);

        // write clears interrupt, unknown code is a no-op
        host_write(16'h0001);
        wait_cyc(30);
        nc = n_conv; nk = n_cal;
        host_write(16'h0008);
        check(int_n === 1, "R7 write clears interrupt", int_n, 1);
        wait_cyc(30);
        check(n_conv == nc && n_cal == nk, "R11 unknown code starts nothing",
              n_conv + n_cal, nc + nk);
        host_read(rv);
        check(rv === 16'h0AAA, "R11 result unchanged", rv, 16'h0AAA);

        // calibration and status
        host_write(16'h0002);
        wait_cyc(310);
        check(t_int - t_cal == CAL_N, "R4 calibrate length", t_int - t_cal, CAL_N);
        host_write(16'h0004);
        host_read(rv);
        check(rv === 16'h8000, "R9 status shows flag", rv, 16'h8000);
        host_read(rv);
        check(rv === 16'h0AAA, "R9 reverts to result", rv, 16'h0AAA);

        // convert and calibrate ignored during calibration
        host_write(16'h0002);
        wait_cyc(3);
        nc = n_conv; nk = n_cal;
        host_write(16'h0001);
        host_write(16'h0002);
        wait_cyc(310);
        check(n_conv == nc && n_cal == nk, "R6 commands ignored while calibrating",
              n_conv + n_cal, nc + nk);
        check(t_int - t_cal == CAL_N, "R6 calibration not disturbed", t_int - t_cal, CAL_N);

        // calibrate ignored during conversion; flag survives conversion
        core_result = 13'h0042;
        host_write(16'h0001);
        nk = n_cal;
        host_write(16'h0002);
        wait_cyc(30);
        check(n_cal == nk, "R6 calibrate ignored while converting", n_cal, nk);
        host_write(16'h0004);
        host_read(rv);
        check(rv === 16'h8000, "R4 flag kept across conversion", rv, 16'h8000);
        host_read(rv);
        check(rv === 16'h0042, "R3 result stored", rv, 16'h0042);

        wait_cyc(5);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule